// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block is the decision core of an eight-line interrupt controller. It samples the raw request lines and holds one pending bit per line. A per-line trigger-kind input picks the capture rule. A level line's pending bit follows the line. An edge line's pending bit is set by a rising edge and stays set until that line is acknowledged. The pending bits that are not masked are searched in a ring that starts at a rotation base. The offset from the base gives the priority, and offset 0 is the most urgent. The best pending line is then compared with the most urgent in-service line, and a request is raised only when the pending line strictly outranks it.

The surrounding logic gives the acknowledge strobe with the index it accepted, which marks that line in service. It gives an end-of-interrupt strobe with an index, which retires that line from service. It can also load a new rotation base. Optional modes are an automatic end-of-interrupt, an automatic rotation after each acknowledge, and a nested mode that leaves the cascade slot out of the in-service comparison. Address decoding, cascading of several units and vector formation belong to the surrounding logic.

Top module: `irq_prio_core`

## Requirements
- R1: A line with `line_is_level` bit = 1 has its pending bit equal to the line value sampled at the last clock edge, so the request is withdrawn when the line falls.
- R2: A line with `line_is_level` bit = 0 sets its pending bit only on a clock edge where it is high and its sample from the previous edge was low. A line that stays high does not request again. Capture happens whether or not the line is masked.
- R3: A line whose `line_mask` bit is 1 is excluded from the search but keeps its pending bit. Clearing the mask later raises it.
- R4: The search starts at the rotation base and wraps modulo 8. The reported `irq_sel` is (winning offset + base) mod 8. A `base_load` pulse replaces the base with `base_val`. The base is 0 after reset.
- R5: `irq_raise` is 1 only when the best pending unmasked offset is strictly lower than the best in-service offset. An empty set counts as offset 8. A pending line that is also in service does not raise.
- R6: An `ack_stb` pulse sets the in-service bit of `ack_sel`. It clears the pending bit of that line only for edge lines. A level line keeps its pending bit.
- R7: An `eoi_stb` pulse clears the in-service bit selected by `eoi_sel`. This lets lower-ranked pending lines raise.
- R8: With `auto_eoi_en` = 1, an acknowledge does not set the in-service bit.
- R9: With `auto_eoi_en` = 1 and `auto_rot_en` = 1, an acknowledge of line k sets the base to (k+1) mod 8. A `base_load` in the same cycle takes precedence.
- R10: With `nest_skip_en` = 1, in-service bit 2 (the cascade slot) is left out of the in-service comparison.
- R11: `irq_raise` and `irq_sel` are registered. They reflect a state change on the next clock edge. `irq_sel` is 0 whenever `irq_raise` is 0.
- R12: After reset the pending, in-service and previous-sample bits are 0, and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_req | input | 8 | Raw request lines |
| line_is_level | input | 8 | Per-line trigger kind, 1 = level, 0 = edge |
| line_mask | input | 8 | Per-line mask, 1 = excluded from search |
| ack_stb | input | 1 | Acknowledge pulse |
| ack_sel | input | 3 | Index of the acknowledged line |
| eoi_stb | input | 1 | End-of-interrupt pulse |
| eoi_sel | input | 3 | Index of the line leaving service |
| base_load | input | 1 | Load the rotation base |
| base_val | input | 3 | New rotation base |
| auto_eoi_en | input | 1 | Automatic end-of-interrupt mode |
| auto_rot_en | input | 1 | Rotate the base on automatic end-of-interrupt |
| nest_skip_en | input | 1 | Ignore the cascade slot in the in-service comparison |
| irq_raise | output | 1 | Registered interrupt request |
| irq_sel | output | 3 | Registered index of the winning line |

## Verification
Level-only patterns are checked with several rotation bases and masks. These patterns show whether the ring search wraps correctly and whether masked lines are skipped. Edge lines are checked with lines held high across an acknowledge. This separates a true rising-edge detector from a level copy, and the mirror test on a level line shows that its pending bit survives the acknowledge. Nesting patterns place one line in service and then raise one line ranked above it and one ranked below it. They also raise a line of equal rank, which exposes a compare that is not strict. The automatic rotation and cascade-slot patterns show that the base moves to the line after the acknowledged one, and that in-service bit 2 is ignored only while the nested mode is on.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_kind_e;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture
    import irq_prio_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_req,
    input  logic [N_LINES-1:0] line_is_level,
    input  logic               ack_stb,
    input  logic [IW-1:0]      ack_sel,
    output logic [N_LINES-1:0] pend_bits
);

    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] irr_q;
    logic [N_LINES-1:0] irr_d;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic ack_hit;
        assign ack_hit = ack_stb && (ack_sel == IW'(i));

        always_comb begin
            if (trig_kind_e'(line_is_level[i]) == TRIG_LEVEL) begin
                irr_d[i] = line_req[i];
            end else begin
                irr_d[i] = (irr_q[i] & ~ack_hit) | (line_req[i] & ~prev_q[i]);
            end
        end

        // Edge-line pending bit only rises after a sampled low-to-high step
        assert_edge_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(irr_q[i]) && !$past(line_is_level[i]))
                |-> ($past(line_req[i]) && !$past(prev_q[i])));

        // Acknowledge never drops an asserted level line
        assert_level_keep_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (line_is_level[i] && line_req[i] && ack_hit) |=> irr_q[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= line_req;
            irr_q  <= irr_d;
        end
    end

    assign pend_bits = irr_q;

endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
    parameter int N_LINES = 8,
    localparam int IW = $clog2(N_LINES),
    localparam int OW = $clog2(N_LINES + 1)
) (
    input  logic [N_LINES-1:0] cand,
    input  logic [IW-1:0]      base,
    output logic [OW-1:0]      best_off
);

    always_comb begin
        logic [IW:0] pos;
        best_off = OW'(N_LINES);
        for (int k = N_LINES - 1; k >= 0; k--) begin
            pos = {1'b0, base} + (IW+1)'(k);
            if (pos >= (IW+1)'(N_LINES)) begin
                pos = pos - (IW+1)'(N_LINES);
            end
            if (cand[pos[IW-1:0]]) begin
                best_off = OW'(k);
            end
        end
    end

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int N_LINES      = 8,
    parameter int CASCADE_SLOT = 2,
    localparam int IW = $clog2(N_LINES),
    localparam int OW = $clog2(N_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_req,
    input  logic [N_LINES-1:0] line_is_level,
    input  logic [N_LINES-1:0] line_mask,
    input  logic               ack_stb,
    input  logic [IW-1:0]      ack_sel,
    input  logic               eoi_stb,
    input  logic [IW-1:0]      eoi_sel,
    input  logic               base_load,
    input  logic [IW-1:0]      base_val,
    input  logic               auto_eoi_en,
    input  logic               auto_rot_en,
    input  logic               nest_skip_en,
    output logic               irq_raise,
    output logic [IW-1:0]      irq_sel
);

    logic [N_LINES-1:0] irr;
    logic [N_LINES-1:0] isr_q;
    logic [N_LINES-1:0] isr_d;
    logic [IW-1:0]      base_q;
    logic [IW-1:0]      base_d;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] isr_view;
    logic [OW-1:0]      req_off;
    logic [OW-1:0]      svc_off;
    logic               want;
    logic [IW-1:0]      win_idx;
    logic               irq_q;
    logic [IW-1:0]      idx_q;

    irq_req_capture #(.N_LINES(N_LINES)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_req     (line_req),
        .line_is_level(line_is_level),
        .ack_stb      (ack_stb),
        .ack_sel      (ack_sel),
        .pend_bits    (irr)
    );

    assign pend     = irr & ~line_mask;
    assign isr_view = nest_skip_en ? (isr_q & ~(N_LINES'(1) << CASCADE_SLOT)) : isr_q;

    irq_prio_find #(.N_LINES(N_LINES)) u_find_req (
        .cand    (pend),
        .base    (base_q),
        .best_off(req_off)
    );

    irq_prio_find #(.N_LINES(N_LINES)) u_find_svc (
        .cand    (isr_view),
        .base    (base_q),
        .best_off(svc_off)
    );

    assign want = (req_off < svc_off);

    always_comb begin
        logic [IW:0] sum;
        sum = (IW+1)'(req_off[IW-1:0]) + {1'b0, base_q};
        if (sum >= (IW+1)'(N_LINES)) begin
            sum = sum - (IW+1)'(N_LINES);
        end
        win_idx = sum[IW-1:0];
    end

    always_comb begin
        logic [IW:0] nxt;
        isr_d  = isr_q;
        base_d = base_q;
        if (eoi_stb) begin
            isr_d[eoi_sel] = 1'b0;
        end
        if (ack_stb && !auto_eoi_en) begin
            isr_d[ack_sel] = 1'b1;
        end
        nxt = {1'b0, ack_sel} + (IW+1)'(1);
        if (nxt >= (IW+1)'(N_LINES)) begin
            nxt = '0;
        end
        if (base_load) begin
            base_d = base_val;
        end else if (ack_stb && auto_eoi_en && auto_rot_en) begin
            base_d = nxt[IW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q  <= '0;
            base_q <= '0;
            irq_q  <= 1'b0;
            idx_q  <= '0;
        end else begin
            isr_q  <= isr_d;
            base_q <= base_d;
            irq_q  <= want;
            idx_q  <= want ? win_idx : '0;
        end
    end

    assign irq_raise = irq_q;
    assign irq_sel   = idx_q;

    // Reported winner was pending and unmasked one cycle earlier
    assert_winner_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (($past(pend) & (N_LINES'(1) << idx_q)) != '0));

    // A line already counted in service can never be the raised winner
    assert_winner_not_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (($past(isr_view) & (N_LINES'(1) << idx_q)) == '0));

    // Automatic end-of-interrupt leaves the in-service bit clear
    assert_auto_eoi_no_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && auto_eoi_en && !isr_q[ack_sel]) |=> !isr_q[$past(ack_sel)]);

    // Rotation on automatic end-of-interrupt moves the base past the acknowledged line
    assert_auto_rotate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && auto_eoi_en && auto_rot_en && !base_load)
            |=> (base_q == IW'($past(ack_sel) + IW'(1))));

    // Quiet output carries index zero
    assert_quiet_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_raise |-> (irq_sel == '0));

endmodule

// File: tb/tb_irq_prio_core.sv
module tb_irq_prio_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] line_req = '0;
    logic [7:0] line_is_level = '0;
    logic [7:0] line_mask = '0;
    logic       ack_stb = 1'b0;
    logic [2:0] ack_sel = '0;
    logic       eoi_stb = 1'b0;
    logic [2:0] eoi_sel = '0;
    logic       base_load = 1'b0;
    logic [2:0] base_val = '0;
    logic       auto_eoi_en = 1'b0;
    logic       auto_rot_en = 1'b0;
    logic       nest_skip_en = 1'b0;
    logic       irq_raise;
    logic [2:0] irq_sel;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_prio_core dut (
        .clk(clk), .rst_n(rst_n), .line_req(line_req), .line_is_level(line_is_level),
        .line_mask(line_mask), .ack_stb(ack_stb), .ack_sel(ack_sel), .eoi_stb(eoi_stb),
        .eoi_sel(eoi_sel), .base_load(base_load), .base_val(base_val),
        .auto_eoi_en(auto_eoi_en), .auto_rot_en(auto_rot_en), .nest_skip_en(nest_skip_en),
        .irq_raise(irq_raise), .irq_sel(irq_sel)
    );

    // {base[22:20], mask[19:12], req[11:4], exp_raise[3], exp_idx[2:0]}
    localparam logic [22:0] VEC [9] = '{
        {3'd0, 8'h00, 8'h00, 1'b0, 3'd0},
        {3'd0, 8'h00, 8'h28, 1'b1, 3'd3},
        {3'd0, 8'h08, 8'h28, 1'b1, 3'd5},
        {3'd4, 8'h00, 8'h28, 1'b1, 3'd5},
        {3'd6, 8'h00, 8'h28, 1'b1, 3'd3},
        {3'd7, 8'h00, 8'h81, 1'b1, 3'd7},
        {3'd0, 8'hFF, 8'hFF, 1'b0, 3'd0},
        {3'd1, 8'h02, 8'h03, 1'b1, 3'd0},
        {3'd3, 8'h00, 8'h04, 1'b1, 3'd2}
    };

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic er, input logic [2:0] ei);
        n_cmp++;
        if (irq_raise !== er || irq_sel !== ei) begin
            n_bad++;
            $display("FAIL %s: raise=%0b sel=%0d expected raise=%0b sel=%0d",
                     tag, irq_raise, irq_sel, er, ei);
        end
    endtask

    task automatic do_ack(input logic [2:0] i);
        @(negedge clk);
        ack_stb = 1'b1; ack_sel = i;
        @(negedge clk);
        ack_stb = 1'b0;
        settle();
    endtask

    task automatic do_eoi(input logic [2:0] i);
        @(negedge clk);
        eoi_stb = 1'b1; eoi_sel = i;
        @(negedge clk);
        eoi_stb = 1'b0;
        settle();
    endtask

    task automatic load_base(input logic [2:0] b);
        @(negedge clk);
        base_load = 1'b1; base_val = b;
        @(negedge clk);
        base_load = 1'b0;
    endtask

    task automatic set_lines(input logic [7:0] v);
        @(negedge clk);
        line_req = v;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R12 outputs during reset", 1'b0, 3'd0);
        rst_n = 1'b1;
        settle();
        expect_out("R12 outputs after reset", 1'b0, 3'd0);

        // Level-only table: rotation, masking, wrap, sentinel
        line_is_level = 8'hFF;
        for (int v = 0; v < 9; v++) begin
            load_base(VEC[v][22:20]);
            line_mask = VEC[v][19:12];
            line_req  = VEC[v][11:4];
            settle();
            expect_out($sformatf("R4/R3/R1 vector %0d", v), VEC[v][3], VEC[v][2:0]);
        end
        set_lines(8'h00);
        expect_out("R1 level request withdrawn", 1'b0, 3'd0);
        line_mask = '0;
        load_base(3'd0);

        // Edge capture and no retrigger while held
        line_is_level = 8'h00;
        settle();
        set_lines(8'h10);
        expect_out("R2 rising edge captured", 1'b1, 3'd4);
        do_ack(3'd4);
        expect_out("R6 edge pending cleared on ack", 1'b0, 3'd0);
        do_eoi(3'd4);
        expect_out("R2 held-high line does not rerequest", 1'b0, 3'd0);
        set_lines(8'h00);
        set_lines(8'h10);
        expect_out("R2 new rising edge captured", 1'b1, 3'd4);
        do_ack(3'd4);
        do_eoi(3'd4);
        set_lines(8'h00);

        // Masked edge still captured
        line_mask = 8'h08;
        set_lines(8'h08);
        expect_out("R3 masked line hidden", 1'b0, 3'd0);
        line_mask = 8'h00;
        settle();
        expect_out("R3 unmasked capture appears", 1'b1, 3'd3);
        do_ack(3'd3);
        do_eoi(3'd3);
        set_lines(8'h00);

        // Level line keeps pending across acknowledge
        line_is_level = 8'h40;
        set_lines(8'h40);
        expect_out("R1 level line requests", 1'b1, 3'd6);
        do_ack(3'd6);
        expect_out("R5 equal rank in service blocks", 1'b0, 3'd0);
        do_eoi(3'd6);
        expect_out("R6 level pending kept after ack", 1'b1, 3'd6);
        set_lines(8'h00);
        expect_out("R1 level line falls", 1'b0, 3'd0);
        line_is_level = 8'h00;

        // Nesting against in-service level
        set_lines(8'h08);
        do_ack(3'd3);
        set_lines(8'h28);
        expect_out("R5 lower rank blocked by in-service", 1'b0, 3'd0);
        set_lines(8'h2A);
        expect_out("R5 higher rank preempts", 1'b1, 3'd1);
        do_ack(3'd1);
        expect_out("R6 ack marks line in service", 1'b0, 3'd0);
        do_eoi(3'd1);
        expect_out("R7 remaining service still blocks", 1'b0, 3'd0);
        do_eoi(3'd3);
        expect_out("R7 retire releases lower rank", 1'b1, 3'd5);
        do_ack(3'd5);
        do_eoi(3'd5);
        set_lines(8'h00);

        // Automatic end-of-interrupt without rotation
        auto_eoi_en = 1'b1;
        set_lines(8'h04);
        expect_out("R8 line 2 raised", 1'b1, 3'd2);
        do_ack(3'd2);
        set_lines(8'h84);
        expect_out("R8 no in-service bit after ack", 1'b1, 3'd7);
        do_ack(3'd7);
        set_lines(8'h00);

        // Automatic rotation
        auto_rot_en = 1'b1;
        load_base(3'd0);
        set_lines(8'h22);
        expect_out("R9 base 0 picks line 1", 1'b1, 3'd1);
        do_ack(3'd1);
        expect_out("R9 base moved past line 1", 1'b1, 3'd5);
        do_ack(3'd5);
        set_lines(8'h00);
        set_lines(8'h84);
        expect_out("R9 base 6 ranks line 7 above line 2", 1'b1, 3'd7);
        do_ack(3'd7);
        expect_out("R9 base wrapped to 0", 1'b1, 3'd2);
        do_ack(3'd2);
        set_lines(8'h00);
        auto_eoi_en = 1'b0;
        auto_rot_en = 1'b0;
        load_base(3'd0);

        // Cascade slot skipped in nested mode
        set_lines(8'h04);
        do_ack(3'd2);
        set_lines(8'h00);
        nest_skip_en = 1'b1;
        set_lines(8'h04);
        expect_out("R10 slot 2 service ignored", 1'b1, 3'd2);
        nest_skip_en = 1'b0;
        settle();
        expect_out("R10 slot 2 service counted when off", 1'b0, 3'd0);
        do_eoi(3'd2);
        expect_out("R7 slot 2 retired", 1'b1, 3'd2);
        do_ack(3'd2);
        do_eoi(3'd2);
        set_lines(8'h00);

        // Single-edge latency
        @(negedge clk);
        line_req = 8'h01;
        @(negedge clk);
        expect_out("R11 no output before register stage", 1'b0, 3'd0);
        @(negedge clk);
        expect_out("R11 output one edge after capture", 1'b1, 3'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule